// File: doc/BRIEF.md
# Edge-Sensing GPIO Controller

A 32-line general-purpose I/O block that sits on a simple 32-bit register bus. Each line can be driven as an output or sampled as an input. Outputs drive either push-pull or open-drain. Inputs pass through a two-stage synchroniser before any other logic sees them. The block looks for transitions on every line and records each one as a sticky event bit. Those event bits are then masked, and the survivors are combined into a single interrupt request.

Software picks, line by line, whether only falling transitions count or both directions do. It clears handled events by writing ones to the event register. Input values show up in the data register only on lines whose input buffer has been switched on. Lines configured as outputs read back the value they drive.

The bus uses byte offsets and word-wide accesses. A write takes effect on the clock edge where `wrEn` is high. Read data is registered: it appears on `rdata` one cycle after `rdEn`.

Top module: `gpio_edge_top`

## Requirements
- R1: After reset every register reads 0. All lines are inputs, `pinOe` is 0 and `irq` is 0.
- R2: In every per-line register, line n is held at bit 31−n, while the pin vectors are indexed by line number. The register offsets are: direction 0x00 (1 = output), open-drain 0x04, data/output latch 0x08, event 0x0C, mask 0x10, edge mode 0x14 and input-buffer enable 0x18. Any other offset reads 0, and a write to it does nothing.
- R3: A read of the data register returns the output latch on output lines. On input lines it returns the synchronised pin, gated by that line's input-buffer-enable bit, and 0 when the bit is clear.
- R4: An output line with its open-drain bit at 0 always drives `pinOut` to the latch value. With the open-drain bit at 1, `pinOe` is high only while the latch is 0. Input lines never assert `pinOe`.
- R5: With the edge-mode bit at 0, both rising and falling transitions set the line's event bit. The bit stays set until software clears it.
- R6: With the edge-mode bit at 1, only a falling transition sets the event bit, and a rising transition leaves it clear.
- R7: Writing 1 to an event bit clears it, and writing 0 leaves it unchanged. Writing all ones clears every pending event.
- R8: `irq` is high exactly when some event bit and its mask bit are both 1. A mask of 0 holds `irq` low even while events are pending.
- R9: If a new transition and a clearing write land on the same event bit in the same cycle, the bit stays set.
- R10: A pin change made before rising edge k raises the event bit, and `irq` when unmasked, at rising edge k+2. This covers two synchroniser stages and one edge-detect stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| addr | input | 5 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| pinIn | input | 32 | Pin input values, index = line |
| pinOut | output | 32 | Pin output values, index = line |
| pinOe | output | 32 | Pin output enables, index = line |
| irq | output | 1 | Combined masked interrupt |

## Verification
The hardest case to reach is the race between a new transition and a clearing write on the same event bit. It only arises when the write reaches the bus on exactly the cycle the edge detector fires, which is two clock edges after the pin moves. The stimulus moves the pin on a falling clock edge, waits out the synchroniser edge by edge, and then presents the clearing write in that one slot. Edge-to-interrupt latency is checked the same way, by sampling `irq` on each falling edge after a pin change.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
  localparam int LINES  = 32;
  localparam int ADDR_W = 5;
  localparam int SEL_W  = 3;

  localparam logic [SEL_W-1:0] SEL_DIR  = 3'd0;
  localparam logic [SEL_W-1:0] SEL_ODR  = 3'd1;
  localparam logic [SEL_W-1:0] SEL_DAT  = 3'd2;
  localparam logic [SEL_W-1:0] SEL_EVT  = 3'd3;
  localparam logic [SEL_W-1:0] SEL_MASK = 3'd4;
  localparam logic [SEL_W-1:0] SEL_CTL  = 3'd5;
  localparam logic [SEL_W-1:0] SEL_IBE  = 3'd6;
  localparam logic [SEL_W-1:0] SEL_NONE = 3'd7;

  typedef struct packed {
    logic wrDir;
    logic wrOdr;
    logic wrDat;
    logic wrEvt;
    logic wrMask;
    logic wrCtl;
    logic wrIbe;
    logic rdReq;
    logic [SEL_W-1:0] rdSel;
  } gpioStrobe_t;

  function automatic logic [LINES-1:0] lineToReg(input logic [LINES-1:0] v);
    logic [LINES-1:0] r;
    for (int i = 0; i < LINES; i++) r[LINES-1-i] = v[i];
    return r;
  endfunction
endpackage

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
  import gpio_edge_pkg::*;
(
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  output gpioStrobe_t       strobe
);
  logic [SEL_W-1:0] slot;

  always_comb begin
    slot = (addr[ADDR_W-1:2] <= 3'd6) ? addr[ADDR_W-1:2] : SEL_NONE;
    strobe        = '0;
    strobe.rdReq  = rdEn;
    strobe.rdSel  = slot;
    strobe.wrDir  = wrEn && (slot == SEL_DIR);
    strobe.wrOdr  = wrEn && (slot == SEL_ODR);
    strobe.wrDat  = wrEn && (slot == SEL_DAT);
    strobe.wrEvt  = wrEn && (slot == SEL_EVT);
    strobe.wrMask = wrEn && (slot == SEL_MASK);
    strobe.wrCtl  = wrEn && (slot == SEL_CTL);
    strobe.wrIbe  = wrEn && (slot == SEL_IBE);
  end
endmodule

// File: rtl/gpio_edge_dp.sv
module gpio_edge_dp
  import gpio_edge_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  gpioStrobe_t      strobe,
  input  logic [LINES-1:0] wdata,
  input  logic [LINES-1:0] pinIn,
  output logic [LINES-1:0] rdata,
  output logic [LINES-1:0] pinOut,
  output logic [LINES-1:0] pinOe,
  output logic             irq,
  output logic [LINES-1:0] evtBits,
  output logic [LINES-1:0] maskBits,
  output logic [LINES-1:0] dirBits,
  output logic [LINES-1:0] odrBits
);
  logic [LINES-1:0] dirQ, odrQ, datQ, evtQ, maskQ, ctlQ, ibeQ;
  logic [LINES-1:0] syncA, syncB, prevB;
  logic [LINES-1:0] inReg, prevReg, riseReg, fallReg, hitReg;
  logic [LINES-1:0] clrMask, dataView, rdMux;

  // Two-stage synchroniser plus one history stage, kept in line order.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      syncA <= '0;
      syncB <= '0;
      prevB <= '0;
    end else begin
      syncA <= pinIn;
      syncB <= syncA;
      prevB <= syncB;
    end
  end

  // Reorder to register bit order: line n at bit LINES-1-n.
  for (genvar n = 0; n < LINES; n++) begin : g_order
    assign inReg[LINES-1-n]   = syncB[n];
    assign prevReg[LINES-1-n] = prevB[n];
  end

  assign riseReg = inReg & ~prevReg;
  assign fallReg = ~inReg & prevReg;
  assign hitReg  = fallReg | (riseReg & ~ctlQ);
  assign clrMask = strobe.wrEvt ? wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dirQ  <= '0;
      odrQ  <= '0;
      datQ  <= '0;
      evtQ  <= '0;
      maskQ <= '0;
      ctlQ  <= '0;
      ibeQ  <= '0;
    end else begin
      if (strobe.wrDir)  dirQ  <= wdata;
      if (strobe.wrOdr)  odrQ  <= wdata;
      if (strobe.wrDat)  datQ  <= wdata;
      if (strobe.wrMask) maskQ <= wdata;
      if (strobe.wrCtl)  ctlQ  <= wdata;
      if (strobe.wrIbe)  ibeQ  <= wdata;
      // A fresh edge overrides a clear in the same cycle.
      evtQ <= (evtQ & ~clrMask) | hitReg;
    end
  end

  assign dataView = (inReg & ibeQ & ~dirQ) | (datQ & dirQ);

  always_comb begin
    case (strobe.rdSel)
      SEL_DIR:  rdMux = dirQ;
      SEL_ODR:  rdMux = odrQ;
      SEL_DAT:  rdMux = dataView;
      SEL_EVT:  rdMux = evtQ;
      SEL_MASK: rdMux = maskQ;
      SEL_CTL:  rdMux = ctlQ;
      SEL_IBE:  rdMux = ibeQ;
      default:  rdMux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            rdata <= '0;
    else if (strobe.rdReq) rdata <= rdMux;
  end

  // Pin drive in line order.
  for (genvar n = 0; n < LINES; n++) begin : g_pin
    localparam int B = LINES - 1 - n;
    assign pinOut[n] = datQ[B];
    assign pinOe[n]  = dirQ[B] & (~odrQ[B] | ~datQ[B]);
  end

  assign irq      = |(evtQ & maskQ);
  assign evtBits  = evtQ;
  assign maskBits = maskQ;
  assign dirBits  = dirQ;
  assign odrBits  = odrQ;
endmodule

// File: rtl/gpio_edge_top.sv
module gpio_edge_top
  import gpio_edge_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LINES-1:0]  wdata,
  output logic [LINES-1:0]  rdata,
  input  logic [LINES-1:0]  pinIn,
  output logic [LINES-1:0]  pinOut,
  output logic [LINES-1:0]  pinOe,
  output logic              irq
);
  gpioStrobe_t      strobe;
  logic [LINES-1:0] evtBits, maskBits, dirBits, odrBits;

  gpio_edge_ctrl ctrl_i (
    .wrEn  (wrEn),
    .rdEn  (rdEn),
    .addr  (addr),
    .strobe(strobe)
  );

  gpio_edge_dp dp_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobe  (strobe),
    .wdata   (wdata),
    .pinIn   (pinIn),
    .rdata   (rdata),
    .pinOut  (pinOut),
    .pinOe   (pinOe),
    .irq     (irq),
    .evtBits (evtBits),
    .maskBits(maskBits),
    .dirBits (dirBits),
    .odrBits (odrBits)
  );
endmodule

// File: rtl/gpio_edge_chk.sv
module gpio_edge_chk
  import gpio_edge_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [LINES-1:0]  wdata,
  input logic              irq,
  input logic [LINES-1:0]  pinOe,
  input logic [LINES-1:0]  pinOut,
  input logic [LINES-1:0]  evtBits,
  input logic [LINES-1:0]  maskBits,
  input logic [LINES-1:0]  dirBits,
  input logic [LINES-1:0]  odrBits
);
  logic evtWrite;
  assign evtWrite = wrEn && (addr == 5'h0C);

  // R1: first cycle out of reset is quiet.
  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pinOe == '0 && !irq));

  // R4: input lines never drive; open-drain lines never drive high.
  p_input_undriven_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pinOe & ~lineToReg(dirBits)) == '0);
  p_od_no_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pinOe & pinOut & lineToReg(odrBits)) == '0);

  // R5: event bits only drop through a clearing write.
  p_evt_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !evtWrite |=> (($past(evtBits) & ~evtBits) == '0));

  // R7: bits written with 0 keep their pending state.
  p_w1c_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    evtWrite |=> ((evtBits & $past(evtBits) & ~$past(wdata)) == ($past(evtBits) & ~$past(wdata))));

  // R8: no mask, no interrupt.
  p_mask_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (maskBits == '0) |-> !irq);
endmodule

bind gpio_edge_top gpio_edge_chk chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .wrEn    (wrEn),
  .addr    (addr),
  .wdata   (wdata),
  .irq     (irq),
  .pinOe   (pinOe),
  .pinOut  (pinOut),
  .evtBits (evtBits),
  .maskBits(maskBits),
  .dirBits (dirBits),
  .odrBits (odrBits)
);

// File: tb/gpio_edge_top_tb_top.sv
module gpio_edge_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [31:0] pinIn = '0;
  logic [31:0] pinOut;
  logic [31:0] pinOe;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  localparam logic [4:0] A_DIR = 5'h00, A_ODR = 5'h04, A_DAT = 5'h08, A_EVT = 5'h0C,
                         A_MSK = 5'h10, A_CTL = 5'h14, A_IBE = 5'h18, A_BAD = 5'h1C;
  localparam logic [31:0] L5 = 32'h0400_0000; // line 5 at bit 26

  // dir, ibe, dat, pins, expected data read
  localparam int NV = 6;
  localparam logic [4:0][31:0] VZ = '0;
  localparam logic [NV-1:0][4:0][31:0] VEC = '{
    '{32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0001, 32'h8000_0000},
    '{32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0000},
    '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hA5A5_0F0F, 32'h0000_0000, 32'hA5A5_0F0F},
    '{32'hFFFF_0000, 32'hFFFF_FFFF, 32'h1234_5678, 32'hFFFF_FFFF, 32'h1234_FFFF},
    '{32'h0000_0000, 32'h0000_FFFF, 32'h0000_0000, 32'hF000_0000, 32'h0000_000F},
    '{32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0003, 32'hC000_0000}
  };

  gpio_edge_top dut_i (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pinIn(pinIn), .pinOut(pinOut),
    .pinOe(pinOe), .irq(irq)
  );

  always #4 clk = ~clk;

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    rdEn = 1'b1; addr = a;
    @(negedge clk);
    rdEn = 1'b0;
    d = rdata;
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    waitCyc(3);
    rst_n = 1'b1;

    // R1 reset state
    check({31'd0, irq}, 32'd0, "R1 irq");
    check(pinOe, 32'd0, "R1 pinOe");
    for (int a = 0; a < 7; a++) begin
      rd(5'(a * 4), v);
      check(v, 32'd0, "R1 reg reset");
    end

    // R2 readback and bit order
    wr(A_DIR, 32'h8000_0000);
    rd(A_DIR, v);
    check(v, 32'h8000_0000, "R2 dir readback");
    check(pinOe, 32'h0000_0001, "R2 line0 at bit31");
    wr(A_BAD, 32'hFFFF_FFFF);
    rd(A_BAD, v);
    check(v, 32'd0, "R2 unused offset");
    wr(A_MSK, 32'h0000_5A5A);
    rd(A_MSK, v);
    check(v, 32'h0000_5A5A, "R2 mask readback");
    wr(A_MSK, 32'd0);

    // R3 vector table
    for (int i = 0; i < NV; i++) begin
      wr(A_DIR, VEC[i][4]);
      wr(A_IBE, VEC[i][3]);
      wr(A_DAT, VEC[i][2]);
      @(negedge clk); pinIn = VEC[i][1];
      waitCyc(4);
      rd(A_DAT, v);
      check(v, VEC[i][0], "R3 data view");
    end

    // R4 pin drive
    wr(A_DIR, 32'h2000_0000);
    wr(A_ODR, 32'h2000_0000);
    wr(A_DAT, 32'h2000_0000);
    check(pinOe, 32'h0, "R4 od releases high");
    wr(A_DAT, 32'h0);
    check(pinOe, 32'h4, "R4 od drives low oe");
    check({31'd0, pinOut[2]}, 32'd0, "R4 od drives low value");
    wr(A_ODR, 32'h0);
    wr(A_DAT, 32'h2000_0000);
    check(pinOe, 32'h4, "R4 push-pull oe");
    check({31'd0, pinOut[2]}, 32'd1, "R4 push-pull value");
    wr(A_DIR, 32'h0);

    // prepare edges
    @(negedge clk); pinIn = 32'h0;
    waitCyc(4);
    wr(A_EVT, 32'hFFFF_FFFF);
    rd(A_EVT, v);
    check(v, 32'd0, "R7 clear all");
    wr(A_MSK, L5);
    wr(A_CTL, 32'h0);

    // R10 latency and R5 rising
    @(negedge clk); pinIn[5] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check({31'd0, irq}, 32'd0, "R10 not before third edge");
    @(negedge clk);
    check({31'd0, irq}, 32'd1, "R10 at third edge");
    rd(A_EVT, v);
    check(v, L5, "R5 rising sets event");

    // R7 write-one-to-clear
    wr(A_EVT, 32'h0);
    rd(A_EVT, v);
    check(v, L5, "R7 zero write keeps");
    wr(A_EVT, L5);
    rd(A_EVT, v);
    check(v, 32'd0, "R7 one write clears");
    check({31'd0, irq}, 32'd0, "R8 irq drops");

    // R5 falling in both-edge mode
    @(negedge clk); pinIn[5] = 1'b0;
    waitCyc(4);
    rd(A_EVT, v);
    check(v, L5, "R5 falling sets event");
    wr(A_EVT, L5);

    // R6 falling-only
    wr(A_CTL, L5);
    @(negedge clk); pinIn[5] = 1'b1;
    waitCyc(4);
    rd(A_EVT, v);
    check(v, 32'd0, "R6 rise ignored");
    check({31'd0, irq}, 32'd0, "R6 irq quiet");
    @(negedge clk); pinIn[5] = 1'b0;
    waitCyc(4);
    rd(A_EVT, v);
    check(v, L5, "R6 fall sets event");

    // R8 masking
    wr(A_MSK, 32'h0);
    check({31'd0, irq}, 32'd0, "R8 masked off");
    wr(A_MSK, L5);
    check({31'd0, irq}, 32'd1, "R8 unmasked");
    wr(A_EVT, 32'hFFFF_FFFF);
    rd(A_EVT, v);
    check(v, 32'd0, "R7 all ones clears");

    // R9 edge and clear in the same cycle
    wr(A_CTL, 32'h0);
    @(negedge clk); pinIn[5] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    wrEn = 1'b1; addr = A_EVT; wdata = L5;
    @(negedge clk);
    wrEn = 1'b0;
    rd(A_EVT, v);
    check(v, L5, "R9 edge beats clear");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule